// File: doc/BRIEF.md
# Parallel ADC Bus Conversion Sequencer

This block sits on the host side of an 8-bit sampling converter that has a parallel output bus. On a start request it drives the converter's active-low chip select, write strobe and read strobe, and it watches the converter's active-low interrupt line. It captures the data bus at the end of the read and returns the code to the host with a one-cycle valid pulse. The interrupt line and the data bus pass through a multi-flop synchronizer before the controller uses them. All strobes leave the block from flops.

A two-bit style input picks how the conversion is run. The read-only style holds the read strobe low until the interrupt line reports completion. The timed style gives a write pulse and waits a fixed delay, then forces completion early with a read. The interrupt style gives a write pulse and waits for the interrupt before reading. The pipelined style drops write and read together, which starts a new conversion and returns the result of the previous one. A separate mode pin tells the converter whether to use read-only or write-read operation. Every interval is a parameter in nanoseconds that is rounded up to whole clock cycles, so no minimum time is ever cut short.

Top module: `adc_bus_sequencer`

## Requirements
- R1: After reset, chip select, write and read strobes are high, busy, valid and timeout are low, and the converter mode pin is high.
- R2: A start request is accepted only when busy is low. A start request seen while busy is high has no effect: each accepted request produces exactly one chip-select window, and busy returns low afterwards with no further strobe activity.
- R3: Style 1 (timed). Chip select and the write strobe fall on the same edge. The write strobe stays low for ceil(250 ns / Tclk) cycles. All strobes except chip select then stay high for ceil(250 ns / Tclk) cycles. The read strobe then stays low for ceil(160 ns / Tclk) + SYNC_STAGES cycles. The interrupt line has no effect on this style.
- R4: The result is the synchronized data bus, captured on the edge where the read strobe rises. result_o then equals the code the converter drives during the read.
- R5: result_valid_o is high for exactly one cycle per delivered result. It rises on the edge where all strobes return high.
- R6: Style 2 (interrupt). After a write pulse of the R3 length, the read strobe stays high until the interrupt line has been sampled low through the synchronizer. The read then lasts ceil(160 ns / Tclk) + SYNC_STAGES cycles.
- R7: Style 0 (read-only). The write strobe never falls. The read strobe falls together with chip select and stays low until the interrupt is seen, then for ceil(160 ns / Tclk) + SYNC_STAGES more cycles. An interrupt level seen in the first SYNC_STAGES + 1 cycles of the wait is disregarded.
- R8: Style 3 (pipelined). The write and read strobes fall and rise on the same edges. They stay low for the larger of the write-pulse and read lengths. Busy then stays high with chip select high for ceil(250 ns / Tclk) cycles before a new start can be accepted.
- R9: In style 3 the returned code is the one converted at the previous strobe. The first style-3 conversion after reset, or after a conversion in another style was accepted, is stale and gives no valid pulse.
- R10: In styles 0 and 2, if no interrupt is seen within TIMEOUT_CYCLES cycles of the wait, all strobes are released and timeout_o pulses for exactly one cycle, with no valid pulse.
- R11: The mode pin is set at acceptance: 0 for style 0 and 1 for styles 1, 2 and 3. It holds that value between conversions.
- R12: Chip select stays low without a break from the first strobe fall to the last strobe rise of a conversion. A write or read strobe is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| style_i | input | 2 | Style: 0 read-only, 1 timed, 2 interrupt, 3 pipelined |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_wr_no | output | 1 | Converter write strobe, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_mode_o | output | 1 | Converter mode pin: 0 read-only, 1 write-read |
| adc_int_ni | input | 1 | Converter interrupt, active low, asynchronous |
| adc_data_i | input | DATA_W | Converter data bus, asynchronous |
| result_o | output | DATA_W | Last captured conversion code |
| result_valid_o | output | 1 | One-cycle pulse when result_o holds a fresh code |
| busy_o | output | 1 | High while a conversion or recovery is in progress |
| timeout_o | output | 1 | One-cycle pulse when the interrupt wait expires |

## Verification
The checker assumes that the converter's interrupt line returns high on the rise of read or chip select. It also assumes that the bus carries a stable code by the time the access interval has run out. Given that, it treats strobe ordering, the single-cycle nature of valid and timeout, and the chip-select framing as properties of the block alone. The bench's converter model follows the same rules. It presents the code only once the read has been low for the access time, raises the interrupt only after a set conversion delay, and clears the interrupt on every read or chip-select rise. It changes its outputs on the falling clock edge, so the synchronizer never samples a value in the middle of a change.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      STYLE_READ_ONLY = 2'd0,
      STYLE_TIMED     = 2'd1,
      STYLE_IRQ       = 2'd2,
      STYLE_PIPE      = 2'd3
   } style_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_PULSE,
      ST_GAP,
      ST_WAIT_IRQ,
      ST_READ,
      ST_PIPE_STROBE,
      ST_RECOVER
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic rd_n;
   } strobes_t;

   localparam strobes_t STROBES_OFF = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};

   // Whole cycles covering an interval, never fewer than one.
   function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adc_seq_sync: at least two stages are required");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("adc_seq_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o  = (cnt_q == '0);
   assign count_o = cnt_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 9,
   parameter int WR_CYC      = 13,
   parameter int GAP_CYC     = 13,
   parameter int ACC_CYC     = 10,
   parameter int PIPE_CYC    = 13,
   parameter int TIMEOUT_CYC = 250,
   parameter int IRQ_GUARD   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [1:0]        style_i,
   input  logic              irq_low_i,
   input  logic [DATA_W-1:0] data_i,
   output strobes_t          strobes_o,
   output logic              mode_o,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o,
   output logic              timeout_o,
   output logic              busy_o
);

   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] PIPE_LD = CNT_W'(PIPE_CYC - 1);
   localparam logic [CNT_W-1:0] TO_LD   = CNT_W'(TIMEOUT_CYC - 1);
   localparam logic [CNT_W-1:0] IRQ_OK  = CNT_W'(TIMEOUT_CYC - 1 - IRQ_GUARD);

   seq_state_e       state_q, state_d;
   style_e           style_q, style_sel;
   logic             stale_q, primed_q;
   strobes_t         strobes_q;
   logic             mode_q, valid_q, timeout_q;
   logic [DATA_W-1:0] result_q;

   logic             ph_load, ph_zero;
   logic [CNT_W-1:0] ph_val, ph_count;
   logic             to_load, to_zero;
   logic [CNT_W-1:0] to_count;
   logic             accept, latch, expire;

   adc_seq_timer #(.CNT_W(CNT_W)) u_phase_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (ph_load),
      .load_val_i (ph_val),
      .zero_o     (ph_zero),
      .count_o    (ph_count)
   );

   adc_seq_timer #(.CNT_W(CNT_W)) u_wait_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (to_load),
      .load_val_i (TO_LD),
      .zero_o     (to_zero),
      .count_o    (to_count)
   );

   // Strobe levels that belong to a state.
   function automatic strobes_t strobes_for(input seq_state_e s, input style_e st);
      strobes_t r;
      r = STROBES_OFF;
      case (s)
         ST_WR_PULSE:    begin r.cs_n = 1'b0; r.wr_n = 1'b0; end
         ST_GAP:         r.cs_n = 1'b0;
         ST_WAIT_IRQ:    begin r.cs_n = 1'b0; r.rd_n = (st != STYLE_READ_ONLY); end
         ST_READ:        begin r.cs_n = 1'b0; r.rd_n = 1'b0; end
         ST_PIPE_STROBE: begin r.cs_n = 1'b0; r.wr_n = 1'b0; r.rd_n = 1'b0; end
         default:        r = STROBES_OFF;
      endcase
      return r;
   endfunction

   always_comb begin
      state_d = state_q;
      ph_load = 1'b0;
      ph_val  = '0;
      to_load = 1'b0;
      accept  = 1'b0;
      latch   = 1'b0;
      expire  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               accept = 1'b1;
               case (style_e'(style_i))
                  STYLE_READ_ONLY: begin state_d = ST_WAIT_IRQ; to_load = 1'b1; end
                  STYLE_PIPE:      begin state_d = ST_PIPE_STROBE; ph_load = 1'b1; ph_val = PIPE_LD; end
                  default:         begin state_d = ST_WR_PULSE; ph_load = 1'b1; ph_val = WR_LD; end
               endcase
            end
         end
         ST_WR_PULSE: begin
            if (ph_zero) begin
               if (style_q == STYLE_TIMED) begin
                  state_d = ST_GAP;
                  ph_load = 1'b1;
                  ph_val  = GAP_LD;
               end else begin
                  state_d = ST_WAIT_IRQ;
                  to_load = 1'b1;
               end
            end
         end
         ST_GAP: begin
            if (ph_zero) begin
               state_d = ST_READ;
               ph_load = 1'b1;
               ph_val  = ACC_LD;
            end
         end
         ST_WAIT_IRQ: begin
            if (irq_low_i && (to_count <= IRQ_OK)) begin
               state_d = ST_READ;
               ph_load = 1'b1;
               ph_val  = ACC_LD;
            end else if (to_zero) begin
               state_d = ST_IDLE;
               expire  = 1'b1;
            end
         end
         ST_READ: begin
            if (ph_zero) begin
               state_d = ST_IDLE;
               latch   = 1'b1;
            end
         end
         ST_PIPE_STROBE: begin
            if (ph_zero) begin
               state_d = ST_RECOVER;
               latch   = 1'b1;
               ph_load = 1'b1;
               ph_val  = GAP_LD;
            end
         end
         ST_RECOVER: begin
            if (ph_zero) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign style_sel = accept ? style_e'(style_i) : style_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         style_q   <= STYLE_TIMED;
         stale_q   <= 1'b1;
         primed_q  <= 1'b0;
         strobes_q <= STROBES_OFF;
         mode_q    <= 1'b1;
         valid_q   <= 1'b0;
         timeout_q <= 1'b0;
         result_q  <= '0;
      end else begin
         state_q   <= state_d;
         strobes_q <= strobes_for(state_d, style_sel);
         valid_q   <= latch && !((style_q == STYLE_PIPE) && stale_q);
         timeout_q <= expire;
         if (accept) begin
            style_q  <= style_e'(style_i);
            mode_q   <= (style_e'(style_i) != STYLE_READ_ONLY);
            stale_q  <= !primed_q;
            primed_q <= (style_e'(style_i) == STYLE_PIPE);
         end
         if (latch) result_q <= data_i;
      end
   end

   assign strobes_o = strobes_q;
   assign mode_o    = mode_q;
   assign result_o  = result_q;
   assign valid_o   = valid_q;
   assign timeout_o = timeout_q;
   assign busy_o    = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_bus_sequencer.sv
module adc_bus_sequencer
   import adc_seq_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int CLK_PERIOD_NS  = 20,
   parameter int WR_PULSE_NS    = 250,
   parameter int READ_DELAY_NS  = 250,
   parameter int ACCESS_NS      = 160,
   parameter int TIMEOUT_CYCLES = 250,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [1:0]        style_i,
   output logic              adc_cs_no,
   output logic              adc_wr_no,
   output logic              adc_rd_no,
   output logic              adc_mode_o,
   input  logic              adc_int_ni,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic [DATA_W-1:0] result_o,
   output logic              result_valid_o,
   output logic              busy_o,
   output logic              timeout_o
);

   localparam int WR_CYC   = int'(cycles_for(WR_PULSE_NS, CLK_PERIOD_NS));
   localparam int GAP_CYC  = int'(cycles_for(READ_DELAY_NS, CLK_PERIOD_NS));
   localparam int ACC_CYC  = int'(cycles_for(ACCESS_NS, CLK_PERIOD_NS)) + SYNC_STAGES;
   localparam int PIPE_CYC = int'(max2(WR_CYC, ACC_CYC));
   localparam int MAX_CYC  = int'(max2(max2(PIPE_CYC, GAP_CYC), TIMEOUT_CYCLES));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("adc_bus_sequencer: CLK_PERIOD_NS must be positive");
      end
      if (TIMEOUT_CYCLES < SYNC_STAGES + 4) begin : g_bad_timeout
         $error("adc_bus_sequencer: TIMEOUT_CYCLES too short for the synchronizer");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("adc_bus_sequencer: DATA_W must be positive");
      end
   endgenerate

   logic              int_sync_n;
   logic [DATA_W-1:0] data_sync;
   strobes_t          strobes;

   adc_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (adc_int_ni),
      .q_o    (int_sync_n)
   );

   adc_seq_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (adc_data_i),
      .q_o    (data_sync)
   );

   adc_seq_ctrl #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .WR_CYC      (WR_CYC),
      .GAP_CYC     (GAP_CYC),
      .ACC_CYC     (ACC_CYC),
      .PIPE_CYC    (PIPE_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYCLES),
      .IRQ_GUARD   (SYNC_STAGES + 1)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .style_i   (style_i),
      .irq_low_i (!int_sync_n),
      .data_i    (data_sync),
      .strobes_o (strobes),
      .mode_o    (adc_mode_o),
      .result_o  (result_o),
      .valid_o   (result_valid_o),
      .timeout_o (timeout_o),
      .busy_o    (busy_o)
   );

   assign adc_cs_no = strobes.cs_n;
   assign adc_wr_no = strobes.wr_n;
   assign adc_rd_no = strobes.rd_n;

endmodule

// File: rtl/adc_bus_sequencer_chk.sv
module adc_bus_sequencer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic busy_o,
   input logic adc_cs_no,
   input logic adc_wr_no,
   input logic adc_rd_no,
   input logic adc_mode_o,
   input logic result_valid_o,
   input logic timeout_o
);

   assert_wr_fall_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(adc_wr_no) |-> $past(!busy_o));

   assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_valid_o |=> !result_valid_o);

   assert_valid_strobes_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_valid_o |-> (adc_cs_no && adc_wr_no && adc_rd_no));

   assert_read_only_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adc_mode_o |-> adc_wr_no);

   assert_pipe_strobes_tied_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(adc_rd_no) && !adc_wr_no) |-> $fell(adc_wr_no));

   assert_timeout_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !timeout_o);

   assert_timeout_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> !result_valid_o);

   assert_strobe_needs_cs_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!adc_wr_no || !adc_rd_no) |-> !adc_cs_no);

   assert_cs_means_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adc_cs_no |-> busy_o);

endmodule

bind adc_bus_sequencer adc_bus_sequencer_chk u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .busy_o         (busy_o),
   .adc_cs_no      (adc_cs_no),
   .adc_wr_no      (adc_wr_no),
   .adc_rd_no      (adc_rd_no),
   .adc_mode_o     (adc_mode_o),
   .result_valid_o (result_valid_o),
   .timeout_o      (timeout_o)
);

// File: tb/adc_bus_sequencer_bench.sv
module adc_bus_sequencer_bench;

   localparam int TCLK      = 20;
   localparam int SYNC      = 2;
   localparam int TIMEOUT   = 250;
   localparam int EXP_WR    = (250 + TCLK - 1) / TCLK;
   localparam int EXP_GAP   = (250 + TCLK - 1) / TCLK;
   localparam int EXP_RD    = (160 + TCLK - 1) / TCLK + SYNC;
   localparam int EXP_PIPE  = (EXP_WR > EXP_RD) ? EXP_WR : EXP_RD;
   localparam int MODEL_ACC = 8;
   localparam int MODEL_INT = 20;
   localparam logic [7:0] JUNK = 8'h5A;

   localparam logic [1:0] S_RO = 2'd0, S_TIM = 2'd1, S_IRQ = 2'd2, S_PIPE = 2'd3;

   // {style, code, expected valid, expected result}
   localparam int NVEC = 13;
   localparam logic [18:0] VEC [NVEC] = '{
      {S_TIM,  8'hA5, 1'b1, 8'hA5},
      {S_TIM,  8'h00, 1'b1, 8'h00},
      {S_TIM,  8'hFF, 1'b1, 8'hFF},
      {S_IRQ,  8'h3C, 1'b1, 8'h3C},
      {S_RO,   8'h81, 1'b1, 8'h81},
      {S_PIPE, 8'h11, 1'b0, 8'h00},
      {S_PIPE, 8'h22, 1'b1, 8'h11},
      {S_PIPE, 8'h33, 1'b1, 8'h22},
      {S_TIM,  8'h44, 1'b1, 8'h44},
      {S_PIPE, 8'h66, 1'b0, 8'h00},
      {S_PIPE, 8'h77, 1'b1, 8'h66},
      {S_IRQ,  8'hC3, 1'b1, 8'hC3},
      {S_RO,   8'h7E, 1'b1, 8'h7E}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] style = 2'd1;
   logic       cs_n, wr_n, rd_n, mode, busy, valid, tmo;
   logic       int_n = 1'b1;
   logic [7:0] bus = JUNK;
   logic [7:0] result;

   int checks = 0;
   int errors = 0;
   int cyc_total = 0;

   // converter model knobs and state
   logic       int_en = 1'b1;
   logic [7:0] sample_code = 8'h00;
   logic [7:0] pend_code = 8'h00, out_code = 8'h00, pipe_prev = 8'h00;
   logic       p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
   logic       run = 1'b0;
   int         conv_cnt = 0;
   int         rd_cnt = 0;

   always #(TCLK/2) clk = ~clk;

   adc_bus_sequencer u_adc_bus_sequencer (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .start_i        (start),
      .style_i        (style),
      .adc_cs_no      (cs_n),
      .adc_wr_no      (wr_n),
      .adc_rd_no      (rd_n),
      .adc_mode_o     (mode),
      .adc_int_ni     (int_n),
      .adc_data_i     (bus),
      .result_o       (result),
      .result_valid_o (valid),
      .busy_o         (busy),
      .timeout_o      (tmo)
   );

   // Converter model, updated on the falling edge.
   always @(negedge clk) begin
      logic wf, rf, wrs, rrs, crs, done;
      wf  = p_wr && !wr_n;
      rf  = p_rd && !rd_n;
      wrs = !p_wr && wr_n;
      rrs = !p_rd && rd_n;
      crs = !p_cs && cs_n;
      if (wf && rf) begin
         out_code  <= pipe_prev;
         pipe_prev <= sample_code;
      end else begin
         if (wf) pend_code <= sample_code;
         if (rf) out_code <= mode ? pend_code : sample_code;
      end
      if (rrs || crs) begin
         run = 1'b0;
         conv_cnt = 0;
      end else if ((wrs && !rrs && rd_n) || (rf && !mode)) begin
         run = 1'b1;
         conv_cnt = 0;
      end else if (run) begin
         conv_cnt++;
      end
      done = run && (conv_cnt >= MODEL_INT);
      if (!rd_n) rd_cnt = rd_cnt + 1; else rd_cnt = 0;
      if (rrs || crs) int_n <= 1'b1;
      else int_n <= !(int_en && (done || (mode && !rd_n && wr_n)));
      if (!rd_n && !cs_n && (mode ? (rd_cnt >= MODEL_ACC) : done))
         bus <= (wf && rf) ? pipe_prev : ((rf) ? (mode ? pend_code : sample_code) : out_code);
      else
         bus <= JUNK;
      p_cs <= cs_n;
      p_wr <= wr_n;
      p_rd <= rd_n;
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
      end
   endtask

   // measurements of one conversion
   int m_wr_low, m_rd_low, m_gap, m_rec, m_valid, m_tmo, m_wr_falls, m_cs_falls, m_tied, m_int_at_rd;
   int m_mode;
   logic [7:0] m_res;

   task automatic run_conv(input logic [1:0] st, input logic [7:0] code, input bit extra_start);
      logic pw, pr, pc;
      int   cyc;
      m_wr_low = 0; m_rd_low = 0; m_gap = 0; m_rec = 0; m_valid = 0; m_tmo = 0;
      m_wr_falls = 0; m_cs_falls = 0; m_tied = 0; m_int_at_rd = -1; m_mode = -1; m_res = 8'h00;
      pw = 1'b1; pr = 1'b1; pc = 1'b1;
      @(negedge clk);
      sample_code = code;
      style = st;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (cyc < 4000) begin
         if (extra_start) start = (cyc == 4) || (cyc == 20);
         if (!wr_n) m_wr_low++;
         if (!rd_n) m_rd_low++;
         if (!cs_n && wr_n && rd_n) m_gap++;
         if (busy && cs_n) m_rec++;
         if (valid) begin m_valid++; m_res = result; end
         if (tmo) m_tmo++;
         if (pw && !wr_n) m_wr_falls++;
         if (pc && !cs_n) begin m_cs_falls++; m_mode = int'(mode); end
         if (pr && !rd_n) begin
            m_int_at_rd = int'(int_n);
            if (pw && !wr_n) m_tied = 1;
         end
         pw = wr_n; pr = rd_n; pc = cs_n;
         if (!busy) break;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (pc && !cs_n) m_cs_falls++;
         if (pw && !wr_n) m_wr_falls++;
         if (valid) m_valid++;
         pw = wr_n; pc = cs_n;
      end
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total == 150000) begin
         errors++;
         $display("FAIL watchdog R2: actual %0d cycles expected completion", cyc_total);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(cs_n && wr_n && rd_n, "R1", "strobes in reset", {cs_n, wr_n, rd_n}, 3'b111);
      check(!busy && !valid && !tmo, "R1", "busy/valid/timeout in reset", {busy, valid, tmo}, 0);
      check(mode == 1'b1, "R1", "mode pin in reset", int'(mode), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cs_n && wr_n && rd_n && !busy, "R1", "idle after reset", {cs_n, wr_n, rd_n, busy}, 4'b1110);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] st;
         logic [7:0] code, eres;
         logic       ev;
         {st, code, ev, eres} = VEC[i];
         run_conv(st, code, 1'b0);
         check(m_valid == int'(ev), (st == S_PIPE) ? "R9" : "R5", "valid pulse count", m_valid, int'(ev));
         if (ev) check(m_res == eres, (st == S_PIPE) ? "R9" : "R4", "result code", m_res, eres);
         check(m_cs_falls == 1, "R12", "chip select windows", m_cs_falls, 1);
         check(m_mode == ((st == S_RO) ? 0 : 1), "R11", "mode pin at start", m_mode, (st == S_RO) ? 0 : 1);
         case (st)
            S_TIM: begin
               check(m_wr_low == EXP_WR, "R3", "write low cycles", m_wr_low, EXP_WR);
               check(m_gap == EXP_GAP, "R3", "delay before read", m_gap, EXP_GAP);
               check(m_rd_low == EXP_RD, "R3", "read low cycles", m_rd_low, EXP_RD);
            end
            S_IRQ: begin
               check(m_wr_low == EXP_WR, "R6", "write low cycles", m_wr_low, EXP_WR);
               check(m_int_at_rd == 0, "R6", "interrupt low before read", m_int_at_rd, 0);
               check(m_rd_low == EXP_RD, "R6", "read low cycles", m_rd_low, EXP_RD);
            end
            S_RO: begin
               check(m_wr_falls == 0, "R7", "write strobe falls", m_wr_falls, 0);
               check(m_rd_low >= MODEL_INT + EXP_RD, "R7", "read held through conversion", m_rd_low, MODEL_INT + EXP_RD);
            end
            default: begin
               check(m_tied == 1, "R8", "write and read fall together", m_tied, 1);
               check(m_wr_low == EXP_PIPE && m_rd_low == EXP_PIPE, "R8", "tied strobe low cycles", m_rd_low, EXP_PIPE);
               check(m_rec == EXP_GAP, "R8", "recovery cycles", m_rec, EXP_GAP);
            end
         endcase
      end

      // R2: start pulses during busy are ignored
      run_conv(S_TIM, 8'h9C, 1'b1);
      check(m_wr_falls == 1, "R2", "write pulses with extra starts", m_wr_falls, 1);
      check(m_cs_falls == 1 && m_valid == 1, "R2", "single conversion", m_cs_falls * 10 + m_valid, 11);
      check(m_res == 8'h9C, "R2", "result after extra starts", m_res, 8'h9C);

      // R3: timed style ignores a dead interrupt line
      int_en = 1'b0;
      run_conv(S_TIM, 8'hB7, 1'b0);
      check(m_valid == 1 && m_res == 8'hB7, "R3", "timed result without interrupt", m_res, 8'hB7);
      check(m_tmo == 0, "R3", "no timeout in timed style", m_tmo, 0);

      // R10: interrupt style timeout
      run_conv(S_IRQ, 8'h12, 1'b0);
      check(m_tmo == 1, "R10", "timeout pulses (interrupt style)", m_tmo, 1);
      check(m_valid == 0, "R10", "no valid on timeout", m_valid, 0);
      check(m_rd_low == 0, "R10", "no read on timeout", m_rd_low, 0);
      check(m_gap == TIMEOUT, "R10", "wait length", m_gap, TIMEOUT);

      // R10: read-only style timeout
      run_conv(S_RO, 8'h34, 1'b0);
      check(m_tmo == 1 && m_valid == 0, "R10", "read-only timeout", m_tmo * 10 + m_valid, 10);
      check(cs_n && wr_n && rd_n && !busy, "R10", "released after timeout", {cs_n, wr_n, rd_n, busy}, 4'b1110);
      check(mode == 1'b0, "R11", "mode pin held after read-only", int'(mode), 0);
      int_en = 1'b1;

      // R9: reset clears pipeline priming
      run_conv(S_PIPE, 8'h55, 1'b0);
      run_conv(S_PIPE, 8'h56, 1'b0);
      check(m_valid == 1 && m_res == 8'h55, "R9", "primed pipeline result", m_res, 8'h55);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_conv(S_PIPE, 8'h57, 1'b0);
      check(m_valid == 0, "R9", "stale after reset", m_valid, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule